// File: doc/BRIEF.md
# Serial Configuration Header and Frame Loader

The block takes one configuration bit on every configuration clock. Before a load starts, the line carries idle ones. The block looks for a 4-bit start code in that stream. The 24 bits that follow the code form a length word, sent most significant bit first. After the length word, the stream is read as a fixed number of frames. Each frame has a single start bit, a fixed number of data bits and a 4-bit check field. Every data bit is presented on a strobe. The first frame carries a bit that selects the fast configuration clock, and the block reports each completed frame. Any start or check mismatch stops loading and drives the active-low initialisation line low.

A daisy-chain output, registered by one clock, carries the idle fill and the header on to downstream devices. While this device consumes its own frames, the output is held high. Once all of this device's frames are in, the output follows the input again.

The length word counts configuration clocks. Counting starts with the first clock after the header. When the count runs out and four further clocks have passed, a done-loading flag rises and stays high. Frame length, frame count and the position of the clock-select bit are parameters.

Top module: `cfgld_top`

## Requirements
- R1: While no start code has been seen, the block watches the last four bits received. A ones-only fill is ignored. When the last four bits read 0,0,1,0 in arrival order, the header has begun. `len_valid` goes high on the clock after the 24th length bit and then stays high.
- R2: `len_word` shifts in the 24 bits that follow the start code, most significant bit first. After `len_valid` is high it no longer changes.
- R3: Until `len_valid` is high, `chain_dout` equals the value `cfg_din` had one clock earlier. This covers both the idle fill and the header.
- R4: From the first frame start bit until this device's last frame is complete, or at any time after an error, `chain_dout` is 1.
- R5: Once all NUM_FRAMES frames have been accepted, `chain_dout` again equals `cfg_din` delayed by one clock.
- R6: Each frame is a 0 start bit, then FRAME_BITS data bits, then the check bits 0,1,1,0 in arrival order. For each data bit, `dat_vld` is high on the next clock and `dat_bit` carries that bit.
- R7: `frame_pulse` is high for exactly one clock, on the clock after the last check bit of a frame that has no error.
- R8: A start bit of 1 is a frame error. `init_n` goes low on the next clock and stays low until reset.
- R9: A check bit that differs from the 0,1,1,0 pattern is a frame error, with the same effect on `init_n` as in R8.
- R10: After a frame error, `dat_vld` and `frame_pulse` stay low, the length count stops, and `load_done` does not rise.
- R11: `fast_clk_sel` is 0 after reset. On the clock after data bit FAST_POS of the first frame (counting from 0), it takes the value of that bit. Later frames do not change it.
- R12: Let L be the length word. `load_done` rises L+4 clocks after the clock on which the last length bit arrives, and then stays high.
- R13: After a synchronous reset, `chain_dout` and `init_n` are 1, and every other output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_din | input | 1 | Serial configuration bit |
| chain_dout | output | 1 | Daisy-chain serial output, registered |
| len_word | output | LEN_W | Captured length count |
| len_valid | output | 1 | Header fully received |
| dat_vld | output | 1 | Frame data bit strobe |
| dat_bit | output | 1 | Frame data bit value |
| frame_pulse | output | 1 | One-clock pulse per good frame |
| init_n | output | 1 | Low after a frame error |
| fast_clk_sel | output | 1 | Fast configuration clock selected |
| load_done | output | 1 | Length count plus four clocks expired |

## Verification
Every output is registered, so each result is due on the clock after the bit that causes it. There is one exception: `load_done` is due L+4 clocks after the last header bit. The bench drives a bit just after a falling edge and updates its behavioural model at the rising edge that samples the bit. At the next falling edge it compares all outputs with the model, so every result is checked in the exact cycle it becomes due. The scenarios cover:
- noise before the start code;
- a zero length word, where done rises while frames are still arriving;
- a corrupt start bit;
- a corrupt check bit;
- pass-through after the last frame.

// File: rtl/cfgld_pkg.sv
// Package: shared constants and state types for the configuration loader.
// Assumes serial data arrives one bit per clock, earliest bit first.
package cfgld_pkg;
    localparam logic [3:0] START_CODE = 4'b0010;
    localparam logic [3:0] CHECK_CODE = 4'b0110;
    localparam int         CHECK_W    = 4;
    localparam int         TAIL_CLKS  = 4;

    typedef enum logic [1:0] {
        HS_HUNT  = 2'd0,
        HS_LEN   = 2'd1,
        HS_DONE  = 2'd2
    } hdr_state_t;
endpackage

// File: rtl/cfgld_header.sv
// Module: cfgld_header
// Hunts for the start code in the serial stream, ignoring idle fill, and then
// shifts in the LEN_W-bit length word MSB first. hdr_done is a level that
// stays high after the final length bit until reset.
// Assumes one valid bit on every clock.
module cfgld_header
    import cfgld_pkg::*;
#(
    parameter int LEN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    output logic             hdr_done,
    output logic [LEN_W-1:0] length
);
    localparam int NB_W = $clog2(LEN_W + 1);

    hdr_state_t      st;
    logic [3:0]      window;
    logic [NB_W-1:0] nbits;
    logic [3:0]      window_nxt;

    // Purpose: candidate start-code window including the current bit.
    always_comb begin
        window_nxt = {window[2:0], din};
    end

    // Purpose: header state, code window, length shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= HS_HUNT;
            window <= '1;
            nbits  <= '0;
            length <= '0;
        end else begin
            case (st)
                HS_HUNT: begin
                    window <= window_nxt;
                    if (window_nxt == START_CODE) begin
                        st    <= HS_LEN;
                        nbits <= '0;
                    end
                end
                HS_LEN: begin
                    length <= {length[LEN_W-2:0], din};
                    nbits  <= nbits + 1'b1;
                    if (nbits == NB_W'(LEN_W - 1)) begin
                        st <= HS_DONE;
                    end
                end
                default: begin
                    st <= HS_DONE;
                end
            endcase
        end
    end

    assign hdr_done = (st == HS_DONE);

    AST_IDLE_ONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == HS_HUNT && din) |=> (st == HS_HUNT)); // R1
    AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_done |=> $stable(length)); // R2
endmodule

// File: rtl/cfgld_frames.sv
// Module: cfgld_frames
// Walks NUM_FRAMES frames of (start bit, FRAME_BITS data, 4 check bits).
// Strobes data bits, pulses per good frame, flags errors (sticky) and
// captures the clock-select bit of the first frame.
// Assumes en rises on the clock carrying the first start bit and stays high.
module cfgld_frames
    import cfgld_pkg::*;
#(
    parameter int FRAME_BITS = 8,
    parameter int NUM_FRAMES = 3,
    parameter int FAST_POS   = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic din,
    output logic dat_vld,
    output logic dat_bit,
    output logic frm_pulse,
    output logic err,
    output logic all_done,
    output logic fast_sel
);
    localparam int LAST_POS = FRAME_BITS + CHECK_W;
    localparam int POS_W    = $clog2(LAST_POS + 1);
    localparam int IDX_W    = $clog2(NUM_FRAMES + 1);

    logic [POS_W-1:0] pos;
    logic [IDX_W-1:0] idx;
    logic [POS_W-1:0] rel;
    logic             in_start;
    logic             in_data;
    logic             exp_chk;
    logic             bad;
    logic             active;
    logic             at_last;

    // Purpose: decode the field of the current bit and detect a mismatch.
    always_comb begin
        in_start = (pos == '0);
        in_data  = (pos != '0) && (pos <= POS_W'(FRAME_BITS));
        rel      = pos - POS_W'(FRAME_BITS + 1);
        exp_chk  = CHECK_CODE[2'd3 - rel[1:0]];
        bad      = in_start ? din : (!in_data && (din != exp_chk));
        active   = en && !all_done && !err;
        at_last  = (pos == POS_W'(LAST_POS));
    end

    // Purpose: frame position, frame index, error and completion tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos      <= '0;
            idx      <= '0;
            err      <= 1'b0;
            all_done <= 1'b0;
        end else if (active) begin
            if (bad) begin
                err <= 1'b1;
            end else if (at_last) begin
                pos <= '0;
                idx <= idx + 1'b1;
                if (idx == IDX_W'(NUM_FRAMES - 1)) begin
                    all_done <= 1'b1;
                end
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end

    // Purpose: registered data strobe, data bit and good-frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_vld   <= 1'b0;
            dat_bit   <= 1'b0;
            frm_pulse <= 1'b0;
        end else begin
            dat_vld   <= active && in_data;
            frm_pulse <= active && at_last && !bad;
            if (active && in_data) begin
                dat_bit <= din;
            end
        end
    end

    generate
        if (FAST_POS < FRAME_BITS) begin : g_fast
            // Purpose: latch the clock-select bit from the first frame.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    fast_sel <= 1'b0;
                end else if (active && idx == '0 && pos == POS_W'(FAST_POS + 1)) begin
                    fast_sel <= din;
                end
            end
        end else begin : g_nofast
            assign fast_sel = 1'b0;
        end
    endgenerate

    AST_QUIET_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (!dat_vld && !frm_pulse)); // R10
    AST_PULSE_XOR_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frm_pulse, dat_vld})); // R7
    AST_NO_PULSE_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !frm_pulse); // R9
endmodule

// File: rtl/cfgld_lencnt.sv
// Module: cfgld_lencnt
// Down-counts the captured length once enabled, then runs a fixed tail of
// extra clocks; done stays high afterwards. Loads the length on its first
// enabled clock, so the length input must be stable by then.
module cfgld_lencnt
    import cfgld_pkg::*;
#(
    parameter int LEN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [LEN_W-1:0] length,
    output logic             done
);
    localparam int TAIL_W = $clog2(TAIL_CLKS + 1);

    logic              started;
    logic [LEN_W-1:0]  cnt;
    logic [LEN_W-1:0]  cur;
    logic [TAIL_W-1:0] tail;

    // Purpose: current remaining count, taking the length before the first load.
    always_comb begin
        cur = started ? cnt : length;
    end

    // Purpose: length down-counter followed by the tail counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started <= 1'b0;
            cnt     <= '0;
            tail    <= '0;
        end else if (en) begin
            started <= 1'b1;
            if (cur != '0) begin
                cnt <= cur - 1'b1;
            end else begin
                cnt <= cur;
                if (tail != TAIL_W'(TAIL_CLKS)) begin
                    tail <= tail + 1'b1;
                end
            end
        end
    end

    assign done = (tail == TAIL_W'(TAIL_CLKS));

    AST_TAIL_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tail != '0) |-> (started && cnt == '0)); // R12
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done); // R12
endmodule

// File: rtl/cfgld_top.sv
// Module: cfgld_top
// Configuration bitstream loader: header detection, length count, frame
// checking and daisy-chain output steering. All outputs are registered.
// Assumes one serial bit per clock; writing frames to memory is done elsewhere.
module cfgld_top
    import cfgld_pkg::*;
#(
    parameter int LEN_W      = 24,
    parameter int FRAME_BITS = 8,
    parameter int NUM_FRAMES = 3,
    parameter int FAST_POS   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_din,
    output logic             chain_dout,
    output logic [LEN_W-1:0] len_word,
    output logic             len_valid,
    output logic             dat_vld,
    output logic             dat_bit,
    output logic             frame_pulse,
    output logic             init_n,
    output logic             fast_clk_sel,
    output logic             load_done
);
    logic hdr_done;
    logic frm_err;
    logic frm_all;

    cfgld_header #(.LEN_W(LEN_W)) u_hdr (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (cfg_din),
        .hdr_done (hdr_done),
        .length   (len_word)
    );

    cfgld_frames #(
        .FRAME_BITS (FRAME_BITS),
        .NUM_FRAMES (NUM_FRAMES),
        .FAST_POS   (FAST_POS)
    ) u_frm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (hdr_done),
        .din       (cfg_din),
        .dat_vld   (dat_vld),
        .dat_bit   (dat_bit),
        .frm_pulse (frame_pulse),
        .err       (frm_err),
        .all_done  (frm_all),
        .fast_sel  (fast_clk_sel)
    );

    cfgld_lencnt #(.LEN_W(LEN_W)) u_len (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (hdr_done && !frm_err),
        .length (len_word),
        .done   (load_done)
    );

    // Purpose: pass data downstream except while this device owns the stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_dout <= 1'b1;
        end else begin
            chain_dout <= (!hdr_done || (frm_all && !frm_err)) ? cfg_din : 1'b1;
        end
    end

    assign len_valid = hdr_done;
    assign init_n    = !frm_err;

    AST_CHAIN_HIGH_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_done && !frm_all) |=> chain_dout); // R4
    AST_DONE_NEEDS_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> len_valid); // R12
endmodule

// File: tb/tb_cfgld_top.sv
module tb_cfgld_top;
    localparam int CLK_PERIOD = 10;
    localparam int FB = 8;
    localparam int NF = 3;
    localparam int FP = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b1;
    logic chain_dout, len_valid, dat_vld, dat_bit, frame_pulse;
    logic init_n, fast_clk_sel, load_done;
    logic [23:0] len_word;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    // model state
    int ph, pre_ph, nb, pos, fi, tail;
    logic [3:0] w;
    logic [23:0] m_len, rem;
    logic e_chain, e_dv, e_db, e_pulse, e_init, e_fast, e_done;
    string err_tag;

    cfgld_top #(.LEN_W(24), .FRAME_BITS(FB), .NUM_FRAMES(NF), .FAST_POS(FP)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_din(din), .chain_dout(chain_dout),
        .len_word(len_word), .len_valid(len_valid), .dat_vld(dat_vld),
        .dat_bit(dat_bit), .frame_pulse(frame_pulse), .init_n(init_n),
        .fast_clk_sel(fast_clk_sel), .load_done(load_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        ph = 0; pre_ph = 0; nb = 0; pos = 0; fi = 0; tail = 0;
        w = 4'hF; m_len = '0; rem = '0;
        e_chain = 1; e_dv = 0; e_db = 0; e_pulse = 0; e_init = 1; e_fast = 0; e_done = 0;
    endtask

    task automatic model_step(input logic b);
        int k;
        logic pat;
        pre_ph = ph;
        e_dv = 0; e_pulse = 0;
        e_chain = (pre_ph == 0 || pre_ph == 1 || pre_ph == 3) ? b : 1'b1;
        if (pre_ph == 2 || pre_ph == 3) begin
            if (rem != 0) rem = rem - 1;
            else if (tail < 4) tail++;
        end
        case (pre_ph)
            0: begin
                w = {w[2:0], b};
                if (w == 4'b0010) begin ph = 1; nb = 0; end
            end
            1: begin
                m_len = {m_len[22:0], b};
                nb++;
                if (nb == 24) begin ph = 2; rem = m_len; pos = 0; fi = 0; end
            end
            2: begin
                if (pos == 0) begin
                    if (b) ph = 4; else pos = 1;
                end else if (pos <= FB) begin
                    e_dv = 1; e_db = b;
                    if (fi == 0 && pos == FP + 1) e_fast = b;
                    pos++;
                end else begin
                    k = pos - FB - 1;
                    pat = (k == 1 || k == 2);
                    if (b != pat) ph = 4;
                    else if (k == 3) begin
                        e_pulse = 1; pos = 0; fi++;
                        if (fi == NF) ph = 3;
                    end else pos++;
                end
            end
            default: ;
        endcase
        if (ph == 4) e_init = 0;
        e_done = (tail == 4);
    endtask

    task automatic compare_all();
        string ctag;
        ctag = (pre_ph <= 1) ? "R3" : (pre_ph == 3) ? "R5" : "R4";
        chk(chain_dout === e_chain, ctag, "chain_dout", chain_dout, e_chain);
        chk(len_word === m_len, "R2", "len_word", len_word, m_len);
        chk(len_valid === (ph >= 2), "R1", "len_valid", len_valid, ph >= 2);
        chk(dat_vld === e_dv, (pre_ph == 4) ? "R10" : "R6", "dat_vld", dat_vld, e_dv);
        if (e_dv) chk(dat_bit === e_db, "R6", "dat_bit", dat_bit, e_db);
        chk(frame_pulse === e_pulse, "R7", "frame_pulse", frame_pulse, e_pulse);
        chk(init_n === e_init, err_tag, "init_n", init_n, e_init);
        chk(fast_clk_sel === e_fast, "R11", "fast_clk_sel", fast_clk_sel, e_fast);
        chk(load_done === e_done, (ph == 4) ? "R10" : "R12", "load_done", load_done, e_done);
    endtask

    task automatic step(input logic b);
        din = b;
        @(posedge clk);
        model_step(b);
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset();
        rst_n = 0; din = 1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        model_reset();
        chk(chain_dout === 1'b1 && init_n === 1'b1, "R13", "chain/init", {chain_dout, init_n}, 3);
        chk({len_valid, dat_vld, frame_pulse, fast_clk_sel, load_done} === 5'b0 && len_word === '0,
            "R13", "other outputs", {len_valid, dat_vld, frame_pulse, fast_clk_sel, load_done}, 0);
    endtask

    task automatic send_hdr(input logic [23:0] l);
        for (int i = 0; i < 5; i++) step(1'b1);
        step(1'b0); step(1'b0); step(1'b1); step(1'b0);
        for (int i = 23; i >= 0; i--) step(l[i]);
    endtask

    // corrupt: -1 none, 0 start bit, 1..4 check bit index (1-based)
    task automatic send_frame(input logic [FB-1:0] d, input int corrupt);
        logic [3:0] cc;
        cc = 4'b0110;
        step(corrupt == 0 ? 1'b1 : 1'b0);
        for (int i = 0; i < FB; i++) step(d[i]);
        for (int i = 0; i < 4; i++) step((corrupt == i + 1) ? ~cc[3-i] : cc[3-i]);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        err_tag = "R8";
        model_reset();
        @(negedge clk);
        // R13 reset state
        do_reset();

        // good load with noise before the code (R1), fast bit 1 (R11), pass-through (R5, R12)
        err_tag = "R9";
        step(1'b1); step(1'b0); step(1'b1); step(1'b1);
        step(1'b0); step(1'b0); step(1'b1); step(1'b1);
        send_hdr(24'd40);
        send_frame(8'b1010_0110, -1);
        send_frame(8'b0101_1001, -1);
        send_frame(8'b1111_0000, -1);
        for (int i = 0; i < 10; i++) step(i[0]);
        chk(load_done === 1'b1, "R12", "done after L+4", load_done, 1);

        // check-field error in frame 1 (R9, R10)
        do_reset();
        err_tag = "R9";
        send_hdr(24'd200);
        send_frame(8'b0000_0000, -1);
        send_frame(8'b1100_1010, 3);
        for (int i = 0; i < 12; i++) step(~i[0]);
        chk(init_n === 1'b0 && load_done === 1'b0, "R10", "after check error", {init_n, load_done}, 0);

        // start-bit error in frame 0 (R8, R10)
        do_reset();
        err_tag = "R8";
        send_hdr(24'h00_0003);
        send_frame(8'hFF, 0);
        for (int i = 0; i < 10; i++) step(i[1]);
        chk(init_n === 1'b0, "R8", "init after start error", init_n, 0);

        // zero length: done while frames still arrive; fast bit 0 (R11, R12)
        do_reset();
        err_tag = "R9";
        send_hdr(24'd0);
        send_frame(8'b1111_1101, -1);
        send_frame(8'b1111_1111, -1);
        send_frame(8'b0011_0011, -1);
        for (int i = 0; i < 6; i++) step(1'b0);
        chk(fast_clk_sel === 1'b0, "R11", "fast from frame 0 only", fast_clk_sel, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule